// File: doc/BRIEF.md
# Bouncing LED Scanner

This block drives a row of LEDs so that exactly one of them is lit at any moment. The lit position travels from the leftmost LED to the rightmost one, turns around, travels back, and keeps doing so for as long as it runs. A prescaler counts system clock cycles and sets how often the light moves. By default the light moves ten times per second from a 50 MHz clock.

The light pattern is held in a chain of flip-flops that passes a single 1 from stage to stage on the rising clock edge. A direction flag chooses which neighbour each stage copies. The flag is turned around on the step that lands on an end LED, so each end LED stays lit for one step period only. A synchronous reset returns the light to the leftmost LED. An enable input freezes both the pattern and the prescaler.

Top module: `led_scanner`

## Requirements
- R1: While `rst` is sampled high at a rising edge, the next state lights only the leftmost LED (`led[NUM_LEDS-1]`), sets the direction to rightward and clears the prescaler. After `rst` falls, the first step therefore comes after exactly CLK_HZ/STEP_HZ enabled cycles.
- R2: `led` has exactly one bit set in every cycle after reset.
- R3: The lit position moves at most once per step period. A step happens on the rising edge that ends every CLK_HZ/STEP_HZ-th cycle with `en` high, and `led` does not change on any other edge.
- R4: Rightward means toward lower bit indices. Each step moves the lit bit exactly one position.
- R5: The step that lights `led[0]` turns the direction around. The next step lights `led[1]`.
- R6: The step that lights `led[NUM_LEDS-1]` turns the direction rightward again. A full round trip takes 2*(NUM_LEDS-1) steps, which is 18 for the default width.
- R7: While `en` is low, `led` and the prescaler count hold their values. Counting resumes from the held value.
- R8: `rst` takes effect whatever the level of `en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low freezes pattern and prescaler |
| led | output | NUM_LEDS | One-hot LED row, bit NUM_LEDS-1 is leftmost |

## Verification
The assertions assume that `rst` is asserted at the first clock edge and that `en` and `rst` change only away from the rising edge. The bench meets this by driving both inputs at falling edges and by holding reset from time zero. The one-hot and turn-around properties are only checked outside reset. The bench uses a four-cycle step period. It walks two full round trips and then a run with an irregular enable pattern. After that it resets in the middle of a sweep with `en` high. At every falling edge it compares `led` with a position computed from the count of enabled cycles.

// File: rtl/led_scanner.sv
module led_scanner #(
  parameter int NUM_LEDS = 10,
  parameter int CLK_HZ   = 50_000_000,
  parameter int STEP_HZ  = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  output logic [NUM_LEDS-1:0] led
);
  localparam int STEP_CYCLES = CLK_HZ / STEP_HZ;
  localparam int CNT_W       = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CNT_W-1:0]    LAST_CNT = CNT_W'(STEP_CYCLES - 1);
  localparam logic [NUM_LEDS-1:0] LEFT_ONE = {1'b1, {(NUM_LEDS-1){1'b0}}};

  logic [CNT_W-1:0]    cnt;
  logic                to_right;
  logic                tick;
  logic [NUM_LEDS+1:0] ext;
  logic [NUM_LEDS-1:0] shifted;

  assign tick = en && (cnt == LAST_CNT);
  assign ext  = {1'b0, led, 1'b0};

  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_stage
    assign shifted[i] = to_right ? ext[i+2] : ext[i];
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else if (en)   cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      led      <= LEFT_ONE;
      to_right <= 1'b1;
    end else if (tick) begin
      led <= shifted;
      if (to_right && led[1])                 to_right <= 1'b0;
      else if (!to_right && led[NUM_LEDS-2])  to_right <= 1'b1;
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (led == LEFT_ONE));

  assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(led) == 1);

  assert_only_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(led));

  assert_moves_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
    tick |=> !$stable(led));

  assert_bounce_right_end_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && led[0]) |=> led[1]);

  assert_bounce_left_end_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && led[NUM_LEDS-1]) |=> led[NUM_LEDS-2]);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(led));
endmodule

// File: tb/test_led_scanner.sv
module test_led_scanner;
  localparam int N    = 10;
  localparam int STEP = 4;
  localparam int TRIP = 2 * (N - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [N-1:0] led;

  int checks = 0;
  int errors = 0;
  int ecnt   = 0;
  bit done   = 0;

  led_scanner #(.NUM_LEDS(N), .CLK_HZ(40), .STEP_HZ(10)) i_led_scanner (
    .clk(clk), .rst(rst), .en(en), .led(led)
  );

  always #2 clk = ~clk;

  function automatic logic [N-1:0] expect_led(input int enabled);
    int p;
    int pos;
    p   = (enabled / STEP) % TRIP;
    pos = (p <= N - 1) ? (N - 1 - p) : (p - (N - 1));
    return (N)'(1) << pos;
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: led=%b expected=%b (enabled cycles %0d)", req, act, exp, ecnt);
    end
  endtask

  task automatic cyc(input bit e);
    int p;
    string tag;
    en = e;
    @(posedge clk);
    if (e) ecnt++;
    @(negedge clk);
    p = (ecnt / STEP) % TRIP;
    if (!e)                          tag = "R7";
    else if (p == N - 1 || p == N)   tag = "R5";
    else if (p == 0 && ecnt > 0)     tag = "R6";
    else if (ecnt % STEP != 0)       tag = "R3";
    else                             tag = "R4";
    check(tag, led, expect_led(ecnt));
    checks++;
    if ($countones(led) != 1) begin
      errors++;
      $display("FAIL R2: led=%b has %0d bits set, expected 1", led, $countones(led));
    end
  endtask

  task automatic do_reset(input bit e);
    en  = e;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst  = 1'b0;
    ecnt = 0;
    check(e ? "R8" : "R1", led, {1'b1, {(N-1){1'b0}}});
  endtask

  initial begin
    @(negedge clk);
    do_reset(1'b0);
    for (int k = 0; k < 2 * TRIP * STEP; k++) cyc(1'b1);
    for (int k = 0; k < 90; k++) cyc((k % 3) != 0 && (k % 7) != 5);
    for (int k = 0; k < 5; k++) cyc(1'b0);
    for (int k = 0; k < 13; k++) cyc(1'b1);
    do_reset(1'b1);
    for (int k = 0; k < 3 * STEP; k++) cyc(1'b1);
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule